// File: doc/BRIEF.md
# Floppy Controller Register Sequencer

This block is the programmed-I/O front end of a two-drive, single-density floppy controller. The host sees two word registers. One is a control/status word (CSR) and the other is an 8-bit data register (DBR). Writing the CSR with its start bit set launches a command. Every data byte then passes through the DBR one at a time, paced by a transfer-request flag. The host polls that flag or waits for the interrupt.

A 128-byte sector buffer sits inside the block. Fill and empty commands load and unload the buffer from the host. Read, write and write-with-deleted-mark commands first take a sector number and then a track number through the DBR. They then hand the media access to a separate sector-access unit through a start/done handshake. During the access, that unit reaches the buffer through its own port. On completion the block sets a done flag, an error flag if the returned error code is nonzero, and an interrupt request if enabled. It also places the status byte in the DBR.

Register select is address bit 1 (0 = CSR, 1 = DBR). Address bit 0 selects the odd byte. For byte writes the byte travels on `host_wdata[7:0]`. Reads return the selected register on `host_rdata` in the same cycle. Reading the DBR with `host_rd` is what advances an empty command.

Top module: `floppy_pio_seq`

## Requirements
- R1: After `rst`, the CSR and the DBR both read 0 and `irq` is 0.
- R2: CSR bit positions are GO 0, function 3:1, drive 4, DONE 5, interrupt enable 6, transfer request 7, INIT 14, ERROR 15. Only bits 15, 7, 6 and 5 read back; all other bits read 0.
- R3: A CSR write with GO set is obeyed only while idle. It clears DONE, ERROR, transfer request and `irq`, keeps interrupt enable, drive and function, and resets the buffer pointer. While busy, the same write only updates interrupt enable.
- R4: Function 0 (fill) raises transfer request at once. Each accepted DBR write stores the byte at the pointer, drops transfer request and advances the pointer. Transfer request rises again until 128 bytes have been taken, and then the command completes.
- R5: Function 1 (empty) loads the next buffer byte into the DBR and raises transfer request. A DBR read while transfer request is set drops it and fetches the next byte. After all 128 bytes have been delivered in order, the command completes.
- R6: Functions 2 (write), 3 (read) and 6 (write deleted) clear every status bit except bit 2 and raise transfer request. The first DBR byte gives the sector (low 7 bits) and the second gives the track (8 bits). The block then pulses `acc_start`, with the function, drive, sector and track on the access outputs.
- R7: While busy, a DBR write is ignored unless transfer request is set. A write to the odd DBR address (address 3) is always ignored.
- R8: On completion the block returns to idle and sets DONE. It raises `irq` if interrupt enable is set, and sets ERROR if the new error code is nonzero. The error code is latched, and the status byte goes to the DBR. In the status byte, bit 7 is `drv_ready` of the selected drive, bit 6 is set by function 6, and other bits come from `acc_esr_flags`.
- R9: Function 7 places the stored error code in the DBR and completes without changing the code. Function 5 completes with error code 0 and the status byte in the DBR.
- R10: A CSR write without GO and with interrupt enable 0 clears `irq`. With interrupt enable 1 while DONE is set, it raises `irq`.
- R11: Setting CSR bit 14 clears all registers and pulses `acc_start` with `acc_init` high. When the init access completes, the block sets DONE and status bit 2 and places the status byte in the DBR.
- R12: A CSR byte write merges `host_wdata[7:0]` into the low half (address 0) or the high half (address 1) and keeps the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_byte | input | 1 | Byte access; the byte is on host_wdata[7:0] |
| host_addr | input | 2 | Bit 1 selects register, bit 0 selects odd byte |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected register value |
| irq | output | 1 | Interrupt request |
| drv_ready | input | 2 | Ready flag per drive |
| acc_start | output | 1 | One-cycle start pulse to the sector-access unit |
| acc_init | output | 1 | Marks the access as the init sequence |
| acc_func | output | 3 | Function code of the access |
| acc_drive | output | 1 | Selected drive |
| acc_sector | output | 7 | Requested sector |
| acc_track | output | 8 | Requested track |
| acc_done | input | 1 | Access finished (one-cycle pulse) |
| acc_ecode | input | 8 | Error code returned with acc_done |
| acc_esr_flags | input | 8 | Status bits to add, valid with acc_done |
| acc_buf_addr | input | 7 | Access-unit buffer address |
| acc_buf_we | input | 1 | Access-unit buffer write enable |
| acc_buf_wdata | input | 8 | Access-unit buffer write data |
| acc_buf_rdata | output | 8 | Access-unit buffer read data (one cycle latency) |

## Verification
Fill is driven with an arithmetic byte pattern and empty must return that pattern in order. This separates pointer advance and buffer addressing faults from handshake faults. A second fill sends a back-to-back write pair and an odd-address write, so the byte count at which DONE appears shows whether writes without transfer request leak through. The read command has the access model write an XOR pattern through the access port, which proves the two buffer ports share storage. The write-deleted run returns a nonzero code, and a byte write to the high CSR half must trigger INIT, which tells correct byte merging apart from a plain word write.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_EMPTY_FETCH,
    ST_EMPTY_LOAD,
    ST_EMPTY_WAIT,
    ST_GET_SECT,
    ST_GET_TRACK,
    ST_ACCESS,
    ST_FINISH,
    ST_INIT
  } seq_state_e;

  localparam logic [2:0] FN_FILL   = 3'd0;
  localparam logic [2:0] FN_EMPTY  = 3'd1;
  localparam logic [2:0] FN_WRITE  = 3'd2;
  localparam logic [2:0] FN_READ   = 3'd3;
  localparam logic [2:0] FN_STATUS = 3'd5;
  localparam logic [2:0] FN_WRDEL  = 3'd6;
  localparam logic [2:0] FN_ECODE  = 3'd7;

  localparam int CSR_GO   = 0;
  localparam int CSR_DRV  = 4;
  localparam int CSR_IE   = 6;
  localparam int CSR_INIT = 14;

  localparam logic [7:0] ESR_INIT_DONE = 8'h04;
  localparam logic [7:0] ESR_DELETED   = 8'h40;
  localparam logic [7:0] ESR_KEEP_GO   = 8'h04;

endpackage

// File: rtl/fdc_sector_buf.sv
module fdc_sector_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Two ports, synchronous read; the host port and the access port never write together.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/fdc_seq_core.sv
module fdc_seq_core
  import fdc_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int SECT_W    = 7,
  parameter int TRACK_W   = 8,
  localparam int AW       = $clog2(BUF_BYTES),
  localparam int PTR_W    = AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               host_byte,
  input  logic [1:0]         host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               irq,
  input  logic [1:0]         drv_ready,
  output logic               acc_start,
  output logic               acc_init,
  output logic [2:0]         acc_func,
  output logic               acc_drive,
  output logic [SECT_W-1:0]  acc_sector,
  output logic [TRACK_W-1:0] acc_track,
  input  logic               acc_done,
  input  logic [7:0]         acc_ecode,
  input  logic [7:0]         acc_esr_flags,
  output logic [AW-1:0]      buf_addr,
  output logic               buf_we,
  output logic [7:0]         buf_wdata,
  input  logic [7:0]         buf_rdata
);

  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(BUF_BYTES);

  seq_state_e         state;
  logic               done, err, tr, ie, drv;
  logic [2:0]         func;
  logic [7:0]         dbr, esr, ecode;
  logic [SECT_W-1:0]  sector;
  logic [TRACK_W-1:0] track;
  logic [PTR_W-1:0]   ptr;

  // Host decode
  logic [15:0] csr_cur, csr_eff;
  logic        csr_wr, dbr_wr, dbr_rd, dbr_take;

  assign csr_cur  = {err, 7'b0, tr, ie, done, drv, func, 1'b0};
  assign csr_wr   = host_wr && !host_addr[1];
  assign dbr_wr   = host_wr && host_addr[1] && !host_addr[0];
  assign dbr_rd   = host_rd && host_addr[1];
  assign dbr_take = dbr_wr && ((state == ST_IDLE) || tr);

  always_comb begin
    csr_eff = host_wdata;
    if (host_byte)
      csr_eff = host_addr[0] ? {host_wdata[7:0], csr_cur[7:0]}
                             : {csr_cur[15:8], host_wdata[7:0]};
  end

  logic unused_csr_bits;
  assign unused_csr_bits = ^{csr_eff[15], csr_eff[13:7], csr_eff[5]};

  always_comb begin
    if (host_addr[1]) host_rdata = {8'h00, dbr};
    else              host_rdata = {err, 7'b0, tr, ie, done, 5'b0};
  end

  // Completion decode
  logic       fin_en, fin_keep;
  logic [7:0] fin_flags, fin_code, esr_or, esr_fin;

  always_comb begin
    fin_en    = 1'b0;
    fin_keep  = 1'b0;
    fin_flags = 8'h00;
    fin_code  = 8'h00;
    unique case (state)
      ST_FILL:        fin_en = !tr && (ptr == PTR_FULL);
      ST_EMPTY_FETCH: fin_en = (ptr == PTR_FULL);
      ST_ACCESS: begin
        fin_en    = acc_done;
        fin_flags = acc_esr_flags | ((func == FN_WRDEL) ? ESR_DELETED : 8'h00);
        fin_code  = acc_ecode;
      end
      ST_INIT: begin
        fin_en    = acc_done;
        fin_flags = acc_esr_flags | ESR_INIT_DONE;
        fin_code  = acc_ecode;
      end
      ST_FINISH: begin
        fin_en   = 1'b1;
        fin_keep = (func == FN_ECODE);
      end
      default: ;
    endcase
  end

  assign esr_or  = esr | fin_flags;
  assign esr_fin = {drv_ready[drv], esr_or[6:0]};

  // Buffer host port
  assign buf_addr  = ptr[AW-1:0];
  assign buf_we    = dbr_take && (state == ST_FILL);
  assign buf_wdata = host_wdata[7:0];

  // Sequencer and registers
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      tr        <= 1'b0;
      ie        <= 1'b0;
      drv       <= 1'b0;
      func      <= FN_FILL;
      dbr       <= 8'h00;
      esr       <= 8'h00;
      ecode     <= 8'h00;
      sector    <= '0;
      track     <= '0;
      ptr       <= '0;
      irq       <= 1'b0;
      acc_start <= 1'b0;
      acc_init  <= 1'b0;
    end else begin
      acc_start <= 1'b0;

      unique case (state)
        ST_FILL:        if (!tr && ptr != PTR_FULL) tr <= 1'b1;
        ST_EMPTY_FETCH: if (ptr != PTR_FULL) state <= ST_EMPTY_LOAD;
        ST_EMPTY_LOAD: begin
          dbr   <= buf_rdata;
          ptr   <= ptr + 1'b1;
          tr    <= 1'b1;
          state <= ST_EMPTY_WAIT;
        end
        ST_EMPTY_WAIT: if (dbr_rd && tr) begin
          tr    <= 1'b0;
          state <= ST_EMPTY_FETCH;
        end
        ST_GET_SECT: if (!tr) begin
          tr    <= 1'b1;
          state <= ST_GET_TRACK;
        end
        ST_GET_TRACK: if (!tr) begin
          acc_start <= 1'b1;
          state     <= ST_ACCESS;
        end
        default: ;
      endcase

      if (fin_en) begin
        state <= ST_IDLE;
        done  <= 1'b1;
        if (ie) irq <= 1'b1;
        if (fin_keep) begin
          dbr <= ecode;
        end else begin
          esr   <= esr_fin;
          ecode <= fin_code;
          dbr   <= esr_fin;
          if (fin_code != 8'h00) err <= 1'b1;
        end
      end

      if (dbr_take) begin
        dbr <= host_wdata[7:0];
        unique case (state)
          ST_FILL: begin
            tr  <= 1'b0;
            ptr <= ptr + 1'b1;
          end
          ST_GET_SECT: begin
            tr     <= 1'b0;
            sector <= host_wdata[SECT_W-1:0];
          end
          ST_GET_TRACK: begin
            tr    <= 1'b0;
            track <= host_wdata[TRACK_W-1:0];
          end
          default: ;
        endcase
      end

      if (csr_wr) begin
        if (csr_eff[CSR_INIT]) begin
          done      <= 1'b0;
          err       <= 1'b0;
          tr        <= 1'b0;
          ie        <= 1'b0;
          drv       <= 1'b0;
          func      <= FN_FILL;
          dbr       <= 8'h00;
          esr       <= 8'h00;
          ecode     <= 8'h00;
          sector    <= '0;
          track     <= '0;
          ptr       <= '0;
          irq       <= 1'b0;
          state     <= ST_INIT;
          acc_start <= 1'b1;
          acc_init  <= 1'b1;
        end else if (csr_eff[CSR_GO] && state == ST_IDLE) begin
          done     <= 1'b0;
          err      <= 1'b0;
          irq      <= 1'b0;
          ie       <= csr_eff[CSR_IE];
          drv      <= csr_eff[CSR_DRV];
          func     <= csr_eff[3:1];
          ptr      <= '0;
          acc_init <= 1'b0;
          unique case (csr_eff[3:1])
            FN_FILL: begin
              tr    <= 1'b1;
              state <= ST_FILL;
            end
            FN_EMPTY: begin
              tr    <= 1'b0;
              state <= ST_EMPTY_FETCH;
            end
            FN_WRITE, FN_READ, FN_WRDEL: begin
              tr    <= 1'b1;
              esr   <= esr & ESR_KEEP_GO;
              state <= ST_GET_SECT;
            end
            default: begin
              tr    <= 1'b0;
              state <= ST_FINISH;
            end
          endcase
        end else begin
          ie <= csr_eff[CSR_IE];
          if (!csr_eff[CSR_IE]) irq <= 1'b0;
          else if (done)        irq <= 1'b1;
        end
      end
    end
  end

  assign acc_func   = func;
  assign acc_drive  = drv;
  assign acc_sector = sector;
  assign acc_track  = track;

  // Assertions
  AST_TR_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !tr); // R4
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_FULL); // R5
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE)); // R8
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie); // R10
  AST_START_ENTERS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    acc_start |-> (state == ST_ACCESS || state == ST_INIT)); // R6
  AST_GO_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_eff[CSR_GO] && !csr_eff[CSR_INIT] && state == ST_IDLE)
      |=> (!done && !err && !irq)); // R3

endmodule

// File: rtl/floppy_pio_seq.sv
module floppy_pio_seq #(
  parameter int BUF_BYTES = 128,
  parameter int SECT_W    = 7,
  parameter int TRACK_W   = 8,
  localparam int BUF_AW   = $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               host_byte,
  input  logic [1:0]         host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               irq,
  input  logic [1:0]         drv_ready,
  output logic               acc_start,
  output logic               acc_init,
  output logic [2:0]         acc_func,
  output logic               acc_drive,
  output logic [SECT_W-1:0]  acc_sector,
  output logic [TRACK_W-1:0] acc_track,
  input  logic               acc_done,
  input  logic [7:0]         acc_ecode,
  input  logic [7:0]         acc_esr_flags,
  input  logic [BUF_AW-1:0]  acc_buf_addr,
  input  logic               acc_buf_we,
  input  logic [7:0]         acc_buf_wdata,
  output logic [7:0]         acc_buf_rdata
);

  logic [BUF_AW-1:0] core_buf_addr;
  logic              core_buf_we;
  logic [7:0]        core_buf_wdata;
  logic [7:0]        core_buf_rdata;

  fdc_seq_core #(
    .BUF_BYTES (BUF_BYTES),
    .SECT_W    (SECT_W),
    .TRACK_W   (TRACK_W)
  ) core_i (
    .clk           (clk),
    .rst           (rst),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_byte     (host_byte),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .irq           (irq),
    .drv_ready     (drv_ready),
    .acc_start     (acc_start),
    .acc_init      (acc_init),
    .acc_func      (acc_func),
    .acc_drive     (acc_drive),
    .acc_sector    (acc_sector),
    .acc_track     (acc_track),
    .acc_done      (acc_done),
    .acc_ecode     (acc_ecode),
    .acc_esr_flags (acc_esr_flags),
    .buf_addr      (core_buf_addr),
    .buf_we        (core_buf_we),
    .buf_wdata     (core_buf_wdata),
    .buf_rdata     (core_buf_rdata)
  );

  fdc_sector_buf #(
    .DEPTH (BUF_BYTES),
    .DW    (8)
  ) buf_i (
    .clk     (clk),
    .a_addr  (core_buf_addr),
    .a_we    (core_buf_we),
    .a_wdata (core_buf_wdata),
    .a_rdata (core_buf_rdata),
    .b_addr  (acc_buf_addr),
    .b_we    (acc_buf_we),
    .b_wdata (acc_buf_wdata),
    .b_rdata (acc_buf_rdata)
  );

endmodule

// File: tb/floppy_pio_seq_tb_top.sv
module floppy_pio_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_byte = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        irq;
  logic [1:0]  drv_ready = 2'b01;
  logic        acc_start, acc_init, acc_drive;
  logic [2:0]  acc_func;
  logic [6:0]  acc_sector;
  logic [7:0]  acc_track;
  logic        acc_done = 1'b0;
  logic [7:0]  acc_ecode = 8'h0, acc_esr_flags = 8'h0;
  logic [6:0]  acc_buf_addr = 7'd0;
  logic        acc_buf_we = 1'b0;
  logic [7:0]  acc_buf_wdata = 8'h0;
  logic [7:0]  acc_buf_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  floppy_pio_seq dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_byte(host_byte), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .drv_ready(drv_ready),
    .acc_start(acc_start), .acc_init(acc_init), .acc_func(acc_func),
    .acc_drive(acc_drive), .acc_sector(acc_sector), .acc_track(acc_track),
    .acc_done(acc_done), .acc_ecode(acc_ecode), .acc_esr_flags(acc_esr_flags),
    .acc_buf_addr(acc_buf_addr), .acc_buf_we(acc_buf_we),
    .acc_buf_wdata(acc_buf_wdata), .acc_buf_rdata(acc_buf_rdata)
  );

  int total = 0;
  int failed = 0;

  // Scoreboard queues
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] act_q[$];

  task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops and compares as results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [15:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_val(t, a, e);
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_byte = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_byte = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // Driver side: push expectation, then issue the read whose result goes to the monitor
  task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    logic [15:0] v;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_rd(a, v);
    act_q.push_back(v);
  endtask

  task automatic wait_bit(input int b);
    logic [15:0] v;
    v = 16'h0;
    while (!v[b]) bus_rd(2'd0, v);
  endtask

  task automatic fill_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wait_bit(7);
      bus_wr(2'd2, 16'((base + i * 3) & 8'hFF), 1'b0);
    end
  endtask

  // Sector-access unit model
  logic [7:0] m_code = 8'h0, m_flags = 8'h0;
  logic [2:0] exp_func = 3'd0;
  logic       exp_drive = 1'b0;
  logic [6:0] exp_sector = 7'd0;
  logic [7:0] exp_track = 8'd0;
  int         m_init_seen = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (acc_start) begin
        if (acc_init) m_init_seen++;
        else begin
          check_val("R6 access function", 16'(acc_func), 16'(exp_func));
          check_val("R6 access drive", 16'(acc_drive), 16'(exp_drive));
          check_val("R6 access sector", 16'(acc_sector), 16'(exp_sector));
          check_val("R6 access track", 16'(acc_track), 16'(exp_track));
        end
        repeat (3) @(negedge clk);
        if (!acc_init && acc_func == 3'd3) begin
          for (int i = 0; i < 128; i++) begin
            acc_buf_we = 1'b1;
            acc_buf_addr = 7'(i);
            acc_buf_wdata = 8'(i) ^ 8'hA5;
            @(negedge clk);
          end
          acc_buf_we = 1'b0;
        end
        acc_ecode = m_code;
        acc_esr_flags = m_flags;
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
      end
    end
  end

  task automatic finish_run();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_rd(2'd0, 16'h0000, "R1 CSR after reset");
    chk_rd(2'd2, 16'h0000, "R1 DBR after reset");
    check_val("R1 irq after reset", 16'(irq), 16'h0);

    // R2 readback mask
    bus_wr(2'd0, 16'h0040, 1'b0);
    chk_rd(2'd0, 16'h0040, "R2 IE reads back");
    bus_wr(2'd0, 16'h005E, 1'b0);
    chk_rd(2'd0, 16'h0040, "R2 function/drive bits read 0");

    // R4 fill with IE
    bus_wr(2'd0, 16'h0041, 1'b0);
    chk_rd(2'd0, 16'h00C0, "R4 transfer request at once");
    fill_bytes(128, 1);
    wait_bit(5);
    chk_rd(2'd0, 16'h0060, "R4 fill done after 128 bytes");
    check_val("R8 irq on completion", 16'(irq), 16'h1);
    chk_rd(2'd2, 16'h0080, "R8 DBR holds status with drive ready");

    // R10 interrupt control without GO
    bus_wr(2'd0, 16'h0000, 1'b0);
    check_val("R10 IE=0 clears irq", 16'(irq), 16'h0);
    bus_wr(2'd0, 16'h0040, 1'b0);
    check_val("R10 IE=1 with DONE raises irq", 16'(irq), 16'h1);

    // R5 empty returns fill pattern in order
    bus_wr(2'd0, 16'h0043, 1'b0);
    for (int i = 0; i < 128; i++) begin
      wait_bit(7);
      chk_rd(2'd2, 16'((1 + i * 3) & 8'hFF), "R5 empty byte");
    end
    wait_bit(5);
    chk_rd(2'd2, 16'h0080, "R5 DBR status after empty");

    // R7/R3 second fill, IE off
    bus_wr(2'd0, 16'h0001, 1'b0);
    wait_bit(7);
    @(negedge clk);
    host_addr = 2'd2; host_wdata = 16'h0011; host_byte = 1'b0; host_wr = 1'b1;
    @(negedge clk);
    host_wdata = 16'h0022;
    @(negedge clk);
    host_wr = 1'b0;
    wait_bit(7);
    bus_wr(2'd3, 16'h0099, 1'b1);
    chk_rd(2'd0, 16'h0080, "R7 odd DBR write ignored");
    bus_wr(2'd0, 16'h0003, 1'b0);
    chk_rd(2'd0, 16'h0080, "R3 GO while busy ignored");
    fill_bytes(126, 7);
    wait_bit(7);
    chk_rd(2'd0, 16'h0080, "R7 write without TR not counted");
    fill_bytes(1, 9);
    wait_bit(5);
    chk_rd(2'd0, 16'h0020, "R4 second fill done");

    // R6 read sector on drive 1, IE on
    exp_func = 3'd3; exp_drive = 1'b1; exp_sector = 7'h05; exp_track = 8'h2A;
    m_code = 8'h00; m_flags = 8'h00;
    bus_wr(2'd0, 16'h0057, 1'b0);
    wait_bit(7);
    bus_wr(2'd2, 16'h0085, 1'b0);
    wait_bit(7);
    bus_wr(2'd2, 16'h002A, 1'b0);
    wait_bit(5);
    chk_rd(2'd0, 16'h0060, "R8 read done no error");
    check_val("R8 irq after read", 16'(irq), 16'h1);
    chk_rd(2'd2, 16'h0000, "R8 status drive 1 not ready");
    bus_wr(2'd0, 16'h0003, 1'b0);
    for (int i = 0; i < 128; i++) begin
      wait_bit(7);
      chk_rd(2'd2, 16'(8'(i) ^ 8'hA5), "R6 read data via empty");
    end
    wait_bit(5);

    // R8 write deleted with error
    exp_func = 3'd6; exp_drive = 1'b0; exp_sector = 7'h01; exp_track = 8'h00;
    m_code = 8'h40; m_flags = 8'h08;
    bus_wr(2'd0, 16'h000D, 1'b0);
    wait_bit(7);
    bus_wr(2'd2, 16'h0001, 1'b0);
    wait_bit(7);
    bus_wr(2'd2, 16'h0000, 1'b0);
    wait_bit(5);
    chk_rd(2'd0, 16'h8020, "R8 ERROR on nonzero code");
    chk_rd(2'd2, 16'h00C8, "R8 status deleted+flags+ready");
    check_val("R8 no irq with IE off", 16'(irq), 16'h0);

    // R12 low-byte merge keeps ERROR
    bus_wr(2'd0, 16'h0040, 1'b1);
    chk_rd(2'd0, 16'h8060, "R12 low byte merge");
    check_val("R10 irq raised by IE with DONE", 16'(irq), 16'h1);

    // R9 error code and status functions
    bus_wr(2'd0, 16'h000F, 1'b0);
    wait_bit(5);
    chk_rd(2'd2, 16'h0040, "R9 read error code");
    chk_rd(2'd0, 16'h0020, "R9 error code leaves ERROR clear");
    bus_wr(2'd0, 16'h000B, 1'b0);
    wait_bit(5);
    chk_rd(2'd2, 16'h00C8, "R9 read status");
    bus_wr(2'd0, 16'h000F, 1'b0);
    wait_bit(5);
    chk_rd(2'd2, 16'h0000, "R9 code cleared by status");

    // R11/R12 INIT through high-byte write
    m_code = 8'h00; m_flags = 8'h00;
    bus_wr(2'd1, 16'h0040, 1'b1);
    wait_bit(5);
    check_val("R11 init access started", 16'(m_init_seen), 16'd1);
    chk_rd(2'd0, 16'h0020, "R11 CSR after init");
    chk_rd(2'd2, 16'h0084, "R11 init-done status bit");
    check_val("R11 irq off after init", 16'(irq), 16'h0);

    finish_run();
  end

endmodule